// File: doc/BRIEF.md
# Uncore Event Counter Bank

This block is a bank of event counters placed beside an interconnect protocol adapter. Eight 64-bit counters each watch one line of an incoming event vector. An 8-bit code per counter picks the line. Software controls the bank over a simple 32-bit register bus with byte addresses. It can load and read each counter, pick the events, start or stop all counters, and start or stop each counter on its own. When a counter rolls over, a sticky status bit is set. These status bits feed a maskable interrupt line.

Event codes are packed four to a 32-bit select word. A code that names no event input counts nothing. One reserved code (all ones by default) counts every clock cycle. A parameter picks one of two interrupt register layouts. The standard layout has separate mask, status and clear addresses. The compact layout has two addresses: status and mask. In the compact layout, writing ones to the status address clears those bits. A read returns its data one clock after the request.

Top module: `evc_bank`

## Requirements
- R1: After reset every counter, the global enable, the per-counter enables, the select words and the status bits read 0, every mask bit reads 1, and irq_o is low.
- R2: A counter whose code selects event input k increases by exactly 1 on each clock edge at which evt_i[k] is high, provided both enables are set.
- R3: While bit 0 of the control word at 0x1C00 is 0, no counter changes, whatever the events and per-counter enables are.
- R4: Bit n of the enable word at 0x1C04 gates counter n alone; a counter whose bit is 0 holds its value while the others count.
- R5: Counter n takes its code from the select word at 0x1C80 + 4*(n/4), bits [8*(n%4)+7 : 8*(n%4)].
- R6: The code 0xFF counts every clock cycle. A code of 16 or more, other than 0xFF, never counts, even while all event inputs are high.
- R7: Counter n is read and written as two 32-bit halves: the low half at 0x1D00 + 8*n and the high half at 0x1D04 + 8*n. A low-half read captures the high half, and the next high-half read returns the captured value. A low-half write is held until a high-half write, which loads all 64 bits at once. A load takes priority over an increment in the same cycle.
- R8: When counter n rolls over from all ones to zero, status bit n is set, and it stays set until software clears it. In the standard layout the status word reads at 0x1C78.
- R9: In the standard layout, writing to 0x1C7C clears each status bit written with a 1 and leaves bits written with a 0 unchanged. If a rollover and a clear of the same bit fall in the same cycle, the bit stays set.
- R10: irq_o is high exactly when some status bit is set and its mask bit is 0. A mask bit of 1 blocks that bit. In the standard layout the mask word is at 0x1C70.
- R11: In the compact layout the status word is at 0x1C70, and writing 1s there clears those bits without changing the mask. The mask word is at 0x1C74.
- R12: The word at 0x1CF0 returns the VERSION parameter, and writes to it have no effect.
- R13: Read data appears on rdata_o in the cycle after the read request. Unmapped addresses, and the write-only clear address, read as 0. rdata_o is 0 in every cycle that follows a cycle with no read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Event pulses, one bit per event code |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid one cycle after a read request |
| irq_o | output | 1 | Rollover interrupt, OR of unmasked status bits |

## Verification
Counting is tried with bursts of different lengths on two event lines. Two counters share one code and are split across both select words, so a packing fault shows up as a count on the wrong counter. The global enable and the per-counter enables are each switched off while events keep arriving, which separates a gate that is missing from one that is applied to the wrong counter. With all event inputs held high, a cycle-code counter and an out-of-range-code counter run side by side, and their results differ only through the code decode. Rollovers are forced by preloading values near all ones. One of them is timed so that the wrap lands in the same cycle as a clear, and both interrupt layouts are driven through set, mask and clear.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int unsigned OFS_CTRL     = 32'h1C00;
  localparam int unsigned OFS_ENA      = 32'h1C04;
  localparam int unsigned OFS_IRQ_W0   = 32'h1C70;
  localparam int unsigned OFS_IRQ_W1   = 32'h1C74;
  localparam int unsigned OFS_IRQ_W2   = 32'h1C78;
  localparam int unsigned OFS_IRQ_W3   = 32'h1C7C;
  localparam int unsigned OFS_SEL_BASE = 32'h1C80;
  localparam int unsigned OFS_VER      = 32'h1CF0;
  localparam int unsigned OFS_CNT_BASE = 32'h1D00;

  typedef enum logic {
    IRQ_MAP_STD = 1'b0,
    IRQ_MAP_ALT = 1'b1
  } irq_map_e;
endpackage

// File: rtl/evc_event_sel.sv
module evc_event_sel #(
  parameter int NUM_EVT = 16,
  parameter int CODE_W  = 8,
  parameter logic [CODE_W-1:0] CYCLE_CODE = '1
) (
  input  logic [CODE_W-1:0]  code_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               hit_o
);
  localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [IDX_W-1:0] idx;
  assign idx = code_i[IDX_W-1:0];

  always_comb begin
    if (code_i == CYCLE_CODE) hit_o = 1'b1;
    else if (32'(code_i) < 32'(NUM_EVT)) hit_o = evt_i[idx];
    else hit_o = 1'b0;
  end
endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (ld_i) cnt_o <= ld_val_i;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  // load wins: a loaded counter never reports a wrap
  assign wrap_o = inc_i & ~ld_i & (&cnt_o);

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i) |=> cnt_o == $past(cnt_o) + 1'b1);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(cnt_o));
  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_o == $past(ld_val_i));
endmodule

// File: rtl/evc_irq.sv
module evc_irq #(
  parameter int NUM_CNT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CNT-1:0] wrap_i,
  input  logic [NUM_CNT-1:0] clr_i,
  input  logic               mask_we_i,
  input  logic [NUM_CNT-1:0] mask_wd_i,
  output logic [NUM_CNT-1:0] stat_o,
  output logic [NUM_CNT-1:0] mask_o,
  output logic               irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
      mask_o <= '1;
    end else begin
      stat_o <= (stat_o & ~clr_i) | wrap_i;
      if (mask_we_i) mask_o <= mask_wd_i;
    end
  end

  assign irq_o = |(stat_o & ~mask_o);

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wrap_i) |=> ((stat_o & $past(wrap_i)) == $past(wrap_i)));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~wrap_i)) |=> ((stat_o & $past(clr_i & ~wrap_i)) == '0));
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((stat_o & $past(stat_o)) == $past(stat_o)));
  p_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_o) |-> !irq_o);
endmodule

// File: rtl/evc_bank.sv
module evc_bank import evc_pkg::*; #(
  parameter int       NUM_CNT = 8,
  parameter int       NUM_EVT = 16,
  parameter int       CODE_W  = 8,
  parameter int       DW      = 32,
  parameter int       ADDR_W  = 16,
  parameter logic [CODE_W-1:0] CYCLE_CODE = '1,
  parameter logic [DW-1:0]     VERSION    = 32'h0000_0030,
  parameter irq_map_e IRQ_MAP = IRQ_MAP_STD
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               irq_o
);
  localparam int CNT_W         = 2 * DW;
  localparam int CODES_PER_REG = DW / CODE_W;
  localparam int NUM_SEL       = (NUM_CNT + CODES_PER_REG - 1) / CODES_PER_REG;
  localparam bit ALT           = (IRQ_MAP == IRQ_MAP_ALT);
  localparam int unsigned MASK_OFS = ALT ? OFS_IRQ_W1 : OFS_IRQ_W0;
  localparam int unsigned STAT_OFS = ALT ? OFS_IRQ_W0 : OFS_IRQ_W2;
  localparam int unsigned CLR_OFS  = ALT ? OFS_IRQ_W0 : OFS_IRQ_W3;

  logic wr, rd;
  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  logic hit_ctrl, hit_ena, hit_ver, hit_stat, hit_mask, hit_clr;
  assign hit_ctrl = addr_i == ADDR_W'(OFS_CTRL);
  assign hit_ena  = addr_i == ADDR_W'(OFS_ENA);
  assign hit_ver  = addr_i == ADDR_W'(OFS_VER);
  assign hit_stat = addr_i == ADDR_W'(STAT_OFS);
  assign hit_mask = addr_i == ADDR_W'(MASK_OFS);
  assign hit_clr  = addr_i == ADDR_W'(CLR_OFS);

  logic                          glb_en_q;
  logic [NUM_CNT-1:0]            ena_q;
  logic [NUM_SEL-1:0][DW-1:0]    sel_q;
  logic [NUM_SEL-1:0]            sel_hit;
  logic [DW-1:0]                 wr_lo_q, rd_hi_q;
  logic [NUM_CNT-1:0]            lo_hit, hi_hit, inc, ld, wrap;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0]            stat, mask, clr;

  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel_dec
    assign sel_hit[s] = addr_i == ADDR_W'(OFS_SEL_BASE + 4 * s);
  end

  // counter slices: code decode, gating, storage
  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    localparam int SW = n / CODES_PER_REG;
    localparam int SB = (n % CODES_PER_REG) * CODE_W;
    logic ev_hit;

    assign lo_hit[n] = addr_i == ADDR_W'(OFS_CNT_BASE + 8 * n);
    assign hi_hit[n] = addr_i == ADDR_W'(OFS_CNT_BASE + 8 * n + 4);

    evc_event_sel #(
      .NUM_EVT   (NUM_EVT),
      .CODE_W    (CODE_W),
      .CYCLE_CODE(CYCLE_CODE)
    ) u_sel (
      .code_i(sel_q[SW][SB +: CODE_W]),
      .evt_i (evt_i),
      .hit_o (ev_hit)
    );

    assign inc[n] = glb_en_q & ena_q[n] & ev_hit;
    assign ld[n]  = wr & hi_hit[n];

    evc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (inc[n]),
      .ld_i    (ld[n]),
      .ld_val_i({wdata_i, wr_lo_q}),
      .cnt_o   (cnt[n]),
      .wrap_o  (wrap[n])
    );
  end

  assign clr = (wr && hit_clr) ? wdata_i[NUM_CNT-1:0] : '0;

  evc_irq #(.NUM_CNT(NUM_CNT)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wrap_i   (wrap),
    .clr_i    (clr),
    .mask_we_i(wr & hit_mask),
    .mask_wd_i(wdata_i[NUM_CNT-1:0]),
    .stat_o   (stat),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  // half-word views of the addressed counter
  logic          lo_any, hi_any, sel_any;
  logic [DW-1:0] lo_word, hi_word, sel_word;
  always_comb begin
    lo_any  = 1'b0;
    hi_any  = 1'b0;
    sel_any = 1'b0;
    lo_word = '0;
    hi_word = '0;
    sel_word = '0;
    for (int n = 0; n < NUM_CNT; n++) begin
      if (lo_hit[n]) begin
        lo_any  = 1'b1;
        lo_word = cnt[n][DW-1:0];
        hi_word = cnt[n][CNT_W-1:DW];
      end
      if (hi_hit[n]) hi_any = 1'b1;
    end
    for (int s = 0; s < NUM_SEL; s++) begin
      if (sel_hit[s]) begin
        sel_any  = 1'b1;
        sel_word = sel_q[s];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_en_q <= 1'b0;
      ena_q    <= '0;
      sel_q    <= '0;
      wr_lo_q  <= '0;
      rd_hi_q  <= '0;
    end else begin
      if (wr && hit_ctrl) glb_en_q <= wdata_i[0];
      if (wr && hit_ena)  ena_q    <= wdata_i[NUM_CNT-1:0];
      for (int s = 0; s < NUM_SEL; s++)
        if (wr && sel_hit[s]) sel_q[s] <= wdata_i;
      if (wr && lo_any) wr_lo_q <= wdata_i;
      if (rd && lo_any) rd_hi_q <= hi_word;
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)      rd_mux[0] = glb_en_q;
    else if (hit_ena)  rd_mux[NUM_CNT-1:0] = ena_q;
    else if (hit_ver)  rd_mux = VERSION;
    else if (hit_stat) rd_mux[NUM_CNT-1:0] = stat;
    else if (hit_mask) rd_mux[NUM_CNT-1:0] = mask;
    else if (sel_any)  rd_mux = sel_word;
    else if (lo_any)   rd_mux = lo_word;
    else if (hi_any)   rd_mux = rd_hi_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else rdata_o <= rd ? rd_mux : '0;
  end

  p_rd_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> rdata_o == '0);
  p_version_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit_ver) |=> rdata_o == VERSION);
endmodule

// File: tb/test_evc_bank.sv
module test_evc_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        req_m = 1'b0, req_a = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_m, rd_a;
  logic        irq_m, irq_a;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  evc_bank i_evc_bank (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .req_i(req_m), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_m), .irq_o(irq_m)
  );

  evc_bank #(.IRQ_MAP(evc_pkg::IRQ_MAP_ALT)) i_evc_bank_alt (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .req_i(req_a), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_a), .irq_o(irq_a)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(bit alt, logic [15:0] a, logic [31:0] d);
    if (alt) req_a = 1'b1; else req_m = 1'b1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req_m = 1'b0; req_a = 1'b0; we = 1'b0;
  endtask

  task automatic rd(bit alt, logic [15:0] a, output logic [31:0] d);
    if (alt) req_a = 1'b1; else req_m = 1'b1;
    we = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    d = alt ? rd_a : rd_m;
    req_m = 1'b0; req_a = 1'b0;
  endtask

  task automatic wr64(bit alt, int n, logic [63:0] v);
    wr(alt, 16'(32'h1D00 + 8 * n), v[31:0]);
    wr(alt, 16'(32'h1D04 + 8 * n), v[63:32]);
  endtask

  task automatic rd64(bit alt, int n, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(alt, 16'(32'h1D00 + 8 * n), lo);
    rd(alt, 16'(32'h1D04 + 8 * n), hi);
    v = {hi, lo};
  endtask

  task automatic pulse(int k, int cyc);
    evt[k] = 1'b1;
    repeat (cyc) @(negedge clk);
    evt[k] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic [63:0] v;
    rd64(0, 0, v);        check("R1 counter0", v, 64'h0);
    rd64(0, 7, v);        check("R1 counter7", v, 64'h0);
    rd(0, 16'h1C04, d);   check("R1 enables", 64'(d), 64'h0);
    rd(0, 16'h1C70, d);   check("R1 mask", 64'(d), 64'hFF);
    rd(0, 16'h1C78, d);   check("R1 status", 64'(d), 64'h0);
    rd(0, 16'h1C80, d);   check("R1 select", 64'(d), 64'h0);
    check("R1 irq", 64'(irq_m), 64'h0);
    rd(0, 16'h1C10, d);   check("R13 unmapped", 64'(d), 64'h0);
    rd(0, 16'h1C7C, d);   check("R13 clear reads 0", 64'(d), 64'h0);
  endtask

  task automatic t_version();
    logic [31:0] d;
    rd(0, 16'h1CF0, d);   check("R12 version", 64'(d), 64'h30);
    wr(0, 16'h1CF0, 32'hFFFF_FFFF);
    rd(0, 16'h1CF0, d);   check("R12 version after write", 64'(d), 64'h30);
  endtask

  task automatic t_count();
    logic [63:0] v;
    wr(0, 16'h1C80, 32'h0000_0503);
    wr(0, 16'h1C84, 32'h0000_0003);
    wr(0, 16'h1C04, 32'h13);
    wr(0, 16'h1C00, 32'h1);
    pulse(3, 4);
    pulse(5, 2);
    wr(0, 16'h1C00, 32'h0);
    rd64(0, 0, v); check("R2 counter0 code 3", v, 64'd4);
    rd64(0, 1, v); check("R2 counter1 code 5", v, 64'd2);
    rd64(0, 4, v); check("R5 counter4 from second select word", v, 64'd4);
    rd64(0, 2, v); check("R4 counter2 disabled", v, 64'd0);
  endtask

  task automatic t_global_off();
    logic [63:0] v;
    pulse(3, 3);
    rd64(0, 0, v); check("R3 counter0 held", v, 64'd4);
    rd64(0, 4, v); check("R3 counter4 held", v, 64'd4);
  endtask

  task automatic t_per_enable();
    logic [63:0] v;
    wr(0, 16'h1C04, 32'h10);
    wr(0, 16'h1C00, 32'h1);
    pulse(3, 3);
    wr(0, 16'h1C00, 32'h0);
    rd64(0, 0, v); check("R4 counter0 gated", v, 64'd4);
    rd64(0, 4, v); check("R4 counter4 counts", v, 64'd7);
  endtask

  task automatic t_codes();
    logic [63:0] v;
    wr(0, 16'h1C80, 32'h40FF_0503);
    wr(0, 16'h1C04, 32'h0C);
    evt = '1;
    wr(0, 16'h1C00, 32'h1);
    repeat (5) @(negedge clk);
    wr(0, 16'h1C00, 32'h0);
    evt = '0;
    rd64(0, 2, v); check("R6 cycle code", v, 64'd6);
    rd64(0, 3, v); check("R6 out of range code", v, 64'd0);
  endtask

  task automatic t_rw64();
    logic [63:0] v;
    wr(0, 16'h1C04, 32'h0);
    wr64(0, 5, 64'h0123_4567_89AB_CDEF);
    rd64(0, 5, v); check("R7 64-bit round trip", v, 64'h0123_4567_89AB_CDEF);
    wr(0, 16'h1D30, 32'h0000_DEAD);
    rd64(0, 6, v); check("R7 low write alone held", v, 64'h0);
    wr(0, 16'h1C84, 32'hFF00_0003);
    wr(0, 16'h1C04, 32'h80);
    wr(0, 16'h1C00, 32'h1);
    wr64(0, 7, 64'h0000_0005_0000_0000);
    wr(0, 16'h1C00, 32'h0);
    rd64(0, 7, v); check("R7 load wins over increment", v, 64'h0000_0005_0000_0001);
  endtask

  task automatic t_wrap();
    logic [31:0] d; logic [63:0] v;
    wr(0, 16'h1C04, 32'h01);
    wr64(0, 0, '1);
    wr(0, 16'h1C00, 32'h1);
    pulse(3, 1);
    wr(0, 16'h1C00, 32'h0);
    rd64(0, 0, v);       check("R8 counter wrapped", v, 64'h0);
    rd(0, 16'h1C78, d);  check("R8 status set", 64'(d), 64'h01);
    check("R10 irq masked", 64'(irq_m), 64'h0);
    wr(0, 16'h1C70, 32'hFE);
    check("R10 irq unmasked", 64'(irq_m), 64'h1);
    rd(0, 16'h1C70, d);  check("R10 mask readback", 64'(d), 64'hFE);
    wr(0, 16'h1C7C, 32'h02);
    rd(0, 16'h1C78, d);  check("R9 zero bit no effect", 64'(d), 64'h01);
    wr(0, 16'h1C7C, 32'h01);
    rd(0, 16'h1C78, d);  check("R9 cleared", 64'(d), 64'h0);
    check("R10 irq low after clear", 64'(irq_m), 64'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d; logic [63:0] v;
    wr(0, 16'h1C80, 32'h40FF_FF03);
    wr(0, 16'h1C04, 32'h02);
    wr64(0, 1, 64'hFFFF_FFFF_FFFF_FFFE);
    wr(0, 16'h1C00, 32'h1);
    @(negedge clk);
    wr(0, 16'h1C7C, 32'h02);   // lands on the wrap edge
    wr(0, 16'h1C00, 32'h0);
    rd(0, 16'h1C78, d);  check("R9 set wins over clear", 64'(d), 64'h02);
    rd64(0, 1, v);       check("R8 counter after wrap", v, 64'd1);
    wr(0, 16'h1C7C, 32'h02);
    rd(0, 16'h1C78, d);  check("R9 later clear", 64'(d), 64'h0);
  endtask

  task automatic t_alt();
    logic [31:0] d;
    rd(1, 16'h1C74, d);  check("R11 alt mask reset", 64'(d), 64'hFF);
    wr(1, 16'h1C80, 32'h03);
    wr(1, 16'h1C04, 32'h01);
    wr64(1, 0, '1);
    wr(1, 16'h1C00, 32'h1);
    pulse(3, 1);
    wr(1, 16'h1C00, 32'h0);
    rd(1, 16'h1C70, d);  check("R11 alt status set", 64'(d), 64'h01);
    check("R11 alt irq masked", 64'(irq_a), 64'h0);
    wr(1, 16'h1C74, 32'hFE);
    check("R11 alt irq unmasked", 64'(irq_a), 64'h1);
    wr(1, 16'h1C70, 32'h01);
    rd(1, 16'h1C70, d);  check("R11 alt write-one clear", 64'(d), 64'h0);
    rd(1, 16'h1C74, d);  check("R11 alt mask untouched", 64'(d), 64'hFE);
    check("R11 alt irq low", 64'(irq_a), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_version();
    t_count();
    t_global_off();
    t_per_enable();
    t_codes();
    t_rw64();
    t_wrap();
    t_set_wins();
    t_alt();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule